// File: doc/BRIEF.md
# Peripheral Test Harness Controller

This block holds the test-support logic that sits beside a small serial peripheral on an APB bus. Software writes a five-bit test control word and a two-bit stimulus word through the bus. It can also touch a dedicated strobe address. From these the block derives a single clock-enable, and every clocked element of the peripheral core obeys that enable. In normal mode the enable stays high. In test mode it can be made to pulse only on chosen bus accesses, so that the core advances one step per access and test vectors do not depend on clock frequency.

The block also forms the active-low internal resets for the bus-clock domain and the serial-clock domain. It combines the external resets, a software test-reset bit and a scan-mode pin, and the scan-mode pin takes precedence for automatic pattern testing. When test input selection is on, the block replaces the peripheral's serial receive-data input and frame-sync input with bits that software drives. Only the external bus reset clears the test registers, so they survive the software test reset.

Top module: `apb_test_harness`

## Requirements
- R1: When bit 0 of the control word (test enable) is 0, `clk_en` is 1 at all times.
- R2: When test enable is 1 and bit 1 (clock-gate enable) is 0, `clk_en` is 1 at all times.
- R3: When bits 0, 1 and 2 (strobe-only) are all 1, `clk_en` is 1 only while `psel` and `penable` are both high and `paddr` equals 0x88, for a read or a write. At every other time it is 0.
- R4: When bits 0 and 1 are 1 and bit 2 is 0, `clk_en` equals `psel & penable` for an access to any address.
- R5: When `scan_mode` is 0, `pclk_rst_n` is `presetn` AND NOT bit 3 (test reset), and `sclk_rst_n` is `sclk_rst_ext_n` AND NOT bit 3. Both follow combinationally.
- R6: When `scan_mode` is 1, bit 3 has no effect: `pclk_rst_n` equals `presetn` and `sclk_rst_n` equals `sclk_rst_ext_n`.
- R7: Both test registers are reset to zero asynchronously by `presetn` low and by nothing else. Setting the test-reset bit leaves their contents unchanged.
- R8: When bit 4 (input select) is 1, `rxd_out` equals bit 0 of the stimulus word and `frm_out` equals bit 1. When bit 4 is 0, they equal `rxd_in` and `frm_in`.
- R9: A write with `psel`, `penable` and `pwrite` high loads `pwdata[4:0]` into the control word at offset 0x80, or `pwdata[1:0]` into the stimulus word at offset 0x84, at that clock edge.
- R10: A read access to 0x80 or 0x84 returns the register zero-extended, with unused bits reading 0. A read of any other address returns 0.
- R11: A write to 0x88, or to any unmapped address, changes neither register, whatever its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | External bus reset, active low |
| sclk_rst_ext_n | input | 1 | External serial-domain reset, active low |
| scan_mode | input | 1 | Scan test mode, overrides the test reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB address (byte offset) |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| rxd_in | input | 1 | External serial receive data |
| frm_in | input | 1 | External incoming frame sync |
| rxd_out | output | 1 | Receive data delivered to the core |
| frm_out | output | 1 | Frame sync delivered to the core |
| clk_en | output | 1 | Clock-enable for all core registers |
| pclk_rst_n | output | 1 | Internal bus-domain reset, active low |
| sclk_rst_n | output | 1 | Internal serial-domain reset, active low |

## Verification
`clk_en`, `prdata`, both resets and the two muxed inputs are combinational. The bench therefore samples them one time unit after it changes the inputs, both in the setup phase and in the access phase of each transfer. A register write takes effect at the rising edge that closes its access phase. The results of a write are read at the next falling edge or later, and never within the same phase. The bench sweeps all 32 control words against five addresses, in both the setup and the access phase. It also sweeps every combination of scan mode, external resets and the test-reset bit, and every stimulus and input pattern under both settings of the select bit.

// File: rtl/apb_test_harness.sv
module apb_test_harness #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 'h80,
  parameter int STIM_OFS = 'h84,
  parameter int STRB_OFS = 'h88
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              sclk_rst_ext_n,
  input  logic              scan_mode,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              rxd_in,
  input  logic              frm_in,
  output logic              rxd_out,
  output logic              frm_out,
  output logic              clk_en,
  output logic              pclk_rst_n,
  output logic              sclk_rst_n
);
  localparam int CTRL_W = 5;
  localparam int STIM_W = 2;
  localparam int B_TEN  = 0;
  localparam int B_GATE = 1;
  localparam int B_STRB = 2;
  localparam int B_TRST = 3;
  localparam int B_ISEL = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STIM = ADDR_W'(STIM_OFS);
  localparam logic [ADDR_W-1:0] A_STRB = ADDR_W'(STRB_OFS);

  logic [CTRL_W-1:0] ctrl_q;
  logic [STIM_W-1:0] stim_q;
  logic              access, wr_en, gated, pulse, test_rst;
  logic              unused_wdata;

  assign access = psel & penable;
  assign wr_en  = access & pwrite;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q <= '0;
      stim_q <= '0;
    end else if (wr_en) begin
      if (paddr == A_CTRL) ctrl_q <= pwdata[CTRL_W-1:0];
      if (paddr == A_STIM) stim_q <= pwdata[STIM_W-1:0];
    end
  end

  assign unused_wdata = ^pwdata[DATA_W-1:CTRL_W];

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (paddr == A_CTRL) prdata[CTRL_W-1:0] = ctrl_q;
      else if (paddr == A_STIM) prdata[STIM_W-1:0] = stim_q;
    end
  end

  assign gated  = ctrl_q[B_TEN] & ctrl_q[B_GATE];
  assign pulse  = access & (!ctrl_q[B_STRB] | (paddr == A_STRB));
  assign clk_en = !gated | pulse;

  assign test_rst   = ctrl_q[B_TRST] & !scan_mode;
  assign pclk_rst_n = presetn & !test_rst;
  assign sclk_rst_n = sclk_rst_ext_n & !test_rst;

  assign rxd_out = ctrl_q[B_ISEL] ? stim_q[0] : rxd_in;
  assign frm_out = ctrl_q[B_ISEL] ? stim_q[1] : frm_in;
endmodule

// File: rtl/apb_test_harness_chk.sv
module apb_test_harness_chk #(
  parameter int ADDR_W   = 8,
  parameter int STRB_OFS = 'h88
) (
  input logic              pclk,
  input logic              presetn,
  input logic              sclk_rst_ext_n,
  input logic              scan_mode,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              clk_en,
  input logic              pclk_rst_n,
  input logic              sclk_rst_n,
  input logic              rxd_out,
  input logic              frm_out,
  input logic [4:0]        ctrl_q,
  input logic [1:0]        stim_q
);
  // R1
  normal_ce_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !ctrl_q[0] |-> clk_en);

  // R3
  strobe_ce_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (ctrl_q[2:0] == 3'b111 && !(psel && penable && paddr == ADDR_W'(STRB_OFS))) |-> !clk_en);

  // R4
  any_ce_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (ctrl_q[2:0] == 3'b011) |-> (clk_en == (psel && penable)));

  // R5
  trst_on_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (!scan_mode && ctrl_q[3]) |-> (!pclk_rst_n && !sclk_rst_n));

  // R6
  scan_pass_chk: assert property (@(posedge pclk) disable iff (!presetn)
    scan_mode |-> (pclk_rst_n && sclk_rst_n == sclk_rst_ext_n));

  // R8
  stim_mux_chk: assert property (@(posedge pclk) disable iff (!presetn)
    ctrl_q[4] |-> (rxd_out == stim_q[0] && frm_out == stim_q[1]));

  // R11
  strobe_wr_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == ADDR_W'(STRB_OFS)) |=> ($stable(ctrl_q) && $stable(stim_q)));
endmodule

bind apb_test_harness apb_test_harness_chk #(.ADDR_W(ADDR_W), .STRB_OFS(STRB_OFS)) u_chk (
  .pclk(pclk), .presetn(presetn), .sclk_rst_ext_n(sclk_rst_ext_n), .scan_mode(scan_mode),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .clk_en(clk_en),
  .pclk_rst_n(pclk_rst_n), .sclk_rst_n(sclk_rst_n), .rxd_out(rxd_out), .frm_out(frm_out),
  .ctrl_q(ctrl_q), .stim_q(stim_q)
);

// File: tb/apb_test_harness_tb.sv
module apb_test_harness_tb;
  localparam int CLK_PERIOD = 10;

  logic        pclk = 0, presetn = 0, sclk_rst_ext_n = 1, scan_mode = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        rxd_in = 0, frm_in = 0, rxd_out, frm_out, clk_en, pclk_rst_n, sclk_rst_n;
  int          checks = 0, errors = 0;
  logic        ce_setup, ce_acc;
  logic [31:0] rd_acc;

  apb_test_harness u_dut (.*);

  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    #1 ce_setup = clk_en;
    @(negedge pclk);
    penable = 1;
    #1 begin ce_acc = clk_en; rd_acc = prdata; end
    @(posedge pclk);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
  endtask

  function automatic logic exp_ce(input logic [4:0] c, input logic acc, input logic [7:0] a);
    if (!(c[0] && c[1])) return 1'b1;
    if (!acc) return 1'b0;
    return c[2] ? (a == 8'h88) : 1'b1;
  endfunction

  function automatic string ce_req(input logic [4:0] c);
    if (!c[0]) return "R1";
    if (!c[1]) return "R2";
    return c[2] ? "R3" : "R4";
  endfunction

  initial begin
    #(CLK_PERIOD*5000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] addrs [5];
    addrs = '{8'h80, 8'h84, 8'h88, 8'h00, 8'h10};
    #3;
    chk("R7 reset ctrl read", {31'd0, pclk_rst_n}, 32'd0);
    repeat (2) @(negedge pclk);
    presetn = 1;
    #1 chk("R1 reset clk_en", {31'd0, clk_en}, 32'd1);
    bus(0, 8'h80, 0); chk("R7 ctrl zero after reset", rd_acc, 0);
    bus(0, 8'h84, 0); chk("R7 stim zero after reset", rd_acc, 0);

    for (int c = 0; c < 32; c++) begin
      bus(1, 8'h80, 32'hFFFF_FFE0 | c);
      #1 chk(ce_req(c[4:0]), {31'd0, clk_en}, {31'd0, exp_ce(c[4:0], 1'b0, 8'h00)});
      for (int i = 0; i < 5; i++) begin
        for (int w = 0; w < 2; w++) begin
          if (w == 1 && addrs[i] != 8'h88 && addrs[i] != 8'h10) continue;
          bus(w[0], addrs[i], 32'hFFFF_FFFF);
          chk(ce_req(c[4:0]), {31'd0, ce_setup}, {31'd0, exp_ce(c[4:0], 1'b0, addrs[i])});
          chk(ce_req(c[4:0]), {31'd0, ce_acc}, {31'd0, exp_ce(c[4:0], 1'b1, addrs[i])});
          if (w == 0)
            chk("R10 readback", rd_acc, addrs[i] == 8'h80 ? 32'(c) : 32'd0);
        end
      end
      bus(0, 8'h80, 0); chk("R11 ctrl unchanged after strobe write", rd_acc, 32'(c));
      bus(0, 8'h84, 0); chk("R11 stim unchanged", rd_acc, 0);
    end

    for (int t = 0; t < 2; t++) begin
      bus(1, 8'h80, t ? 32'h08 : 32'h00);
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++) begin
          @(negedge pclk); scan_mode = s[0]; sclk_rst_ext_n = e[0];
          #1;
          chk(s ? "R6 pclk" : "R5 pclk", {31'd0, pclk_rst_n}, {31'd0, s[0] | !t[0]});
          chk(s ? "R6 sclk" : "R5 sclk", {31'd0, sclk_rst_n}, {31'd0, e[0] & (s[0] | !t[0])});
        end
      scan_mode = 0; sclk_rst_ext_n = 1;
      bus(0, 8'h80, 0); chk("R7 ctrl survives test reset", rd_acc, t ? 32'h08 : 32'h00);
    end

    for (int sel = 0; sel < 2; sel++) begin
      bus(1, 8'h80, sel ? 32'h10 : 32'h00);
      for (int st = 0; st < 4; st++) begin
        bus(1, 8'h84, 32'hFFFF_FFFC | st);
        bus(0, 8'h84, 0); chk("R9 stim write", rd_acc, 32'(st));
        for (int inp = 0; inp < 4; inp++) begin
          @(negedge pclk); rxd_in = inp[0]; frm_in = inp[1];
          #1;
          chk("R8 rxd", {31'd0, rxd_out}, {31'd0, sel ? st[0] : inp[0]});
          chk("R8 frm", {31'd0, frm_out}, {31'd0, sel ? st[1] : inp[1]});
        end
      end
    end

    bus(1, 8'h84, 32'h3);
    bus(1, 8'h80, 32'h1B);
    @(negedge pclk); presetn = 0;
    #1 chk("R5 bus reset asserts", {31'd0, pclk_rst_n}, 0);
    @(negedge pclk); presetn = 1;
    bus(0, 8'h80, 0); chk("R7 ctrl cleared by bus reset", rd_acc, 0);
    bus(0, 8'h84, 0); chk("R7 stim cleared by bus reset", rd_acc, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule